// File: doc/BRIEF.md
# Strap Capture and Shared-Pin Function Controller

This block reads configuration straps from five dual-purpose pads while the chip is held in reset. Three of the straps are a frequency select code, one is a platform mode, and one selects the processor I/O voltage. While reset is asserted, the pad levels are copied into a strap latch on every system clock edge. The value kept is the one sampled on the last edge before reset is released. After a one-cycle guard interval the block turns the pads into outputs by raising their output enables. They stay outputs until the next reset.

After reset the block drives two things from the latched straps. The first is the effective frequency select code. It comes from the straps, or from a register field when the register source bit is set. The second is the function of four shared power-management pins. In desktop mode these four pins act as extra memory-clock outputs. In mobile mode they act as stop and power-down inputs.

A three-state machine sequences this. STRAP is held while reset is low and samples the pads. On the first clock with reset high it takes the transition STRAP to ARM. ARM keeps every enable low for one cycle. It then always takes ARM to DRIVE. DRIVE is held until reset returns, which forces any state back to STRAP on the next clock.

Top module: `strap_pin_ctrl`

## Requirements
- R1: On every clock edge that samples reset low, the next output state has all pad output enables and all shared-pin output and input enables at 0.
- R2: Pad bits are mapped as follows: bits 2:0 are the frequency code, bit 3 is mode, and bit 4 is voltage select (1 = 2.5 V buffer, 0 = 3.3 V buffer). The latched outputs equal the pad values present at the last clock edge that sampled reset low.
- R3: The pad output enables stay 0 after the first clock edge that samples reset high. They all become 1 after the second such edge.
- R4: From the first clock edge with reset high until the next reset, pad activity has no effect on the latched strap outputs.
- R5: With the source bit at 0 the effective frequency code equals the latched code. With the source bit at 1 it equals the register code. This holds whenever reset is high.
- R6: Once the pads are driven, a latched mode of 1 sets every shared-pin output enable to 1 and every shared-pin input enable to 0. A latched mode of 0 sets every output enable to 0 and every input enable to 1.
- R7: Once the pad output enables are 1, they remain 1 until reset is asserted again.
- R8: A second reset returns the enables to 0 and recaptures new strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, sampled synchronously |
| pad_in | input | 5 | Pad input levels: [2:0] frequency code, [3] mode, [4] voltage select |
| reg_fsel | input | 3 | Frequency code from the configuration register |
| reg_fsel_src | input | 1 | 1 selects the register code, 0 selects the strap code |
| pad_oe | output | 5 | Output enables of the five strap pads |
| strap_fsel | output | 3 | Latched frequency code |
| strap_mode | output | 1 | Latched mode (1 desktop, 0 mobile) |
| strap_vsel | output | 1 | Latched voltage select (1 = 2.5 V, 0 = 3.3 V) |
| eff_fsel | output | 3 | Effective frequency code |
| pm_pin_oe | output | 4 | Shared pins used as memory-clock outputs |
| pm_in_en | output | 4 | Shared pins used as stop/power-down inputs |

## Verification
A state machine stuck in STRAP or ARM would show at the ports as pad_oe staying low two cycles after reset release. A state machine that skips ARM would raise the enables one cycle early, while the pads may still be carrying strap levels. A latch that keeps tracking after release would make strap_fsel follow pad_in within one cycle of a pad change. A wrong mode decode would show on pm_pin_oe and pm_in_en in the first cycle that the pads are driven. The bench changes the pads just after release and again later to expose sampling on the wrong edge.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic [1:0] {
        S_STRAP = 2'd0,
        S_ARM   = 2'd1,
        S_DRIVE = 2'd2
    } strap_state_e;
endpackage

// File: rtl/strap_fsm.sv
module strap_fsm
    import strap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic capture,
    output logic drive
);
    strap_state_e state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_STRAP;
        end else begin
            unique case (state_q)
                S_STRAP: state_q <= S_ARM;
                S_ARM:   state_q <= S_DRIVE;
                S_DRIVE: state_q <= S_DRIVE;
                default: state_q <= S_STRAP;
            endcase
        end
    end

    always_comb begin
        capture = !rst_n;
        drive   = 1'b0;
        unique case (state_q)
            S_STRAP: drive = 1'b0;
            S_ARM:   drive = 1'b0;
            S_DRIVE: drive = 1'b1;
            default: drive = 1'b0;
        endcase
    end
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         cap_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (cap_en) q <= d;
    end
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux #(
    parameter int W = 3
) (
    input  logic         use_reg,
    input  logic [W-1:0] strap_code,
    input  logic [W-1:0] reg_code,
    output logic [W-1:0] eff_code
);
    always_comb eff_code = use_reg ? reg_code : strap_code;
endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl #(
    parameter int FS_W = 3,
    parameter int N_PM = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FS_W+1:0]      pad_in,
    input  logic [FS_W-1:0]      reg_fsel,
    input  logic                 reg_fsel_src,
    output logic [FS_W+1:0]      pad_oe,
    output logic [FS_W-1:0]      strap_fsel,
    output logic                 strap_mode,
    output logic                 strap_vsel,
    output logic [FS_W-1:0]      eff_fsel,
    output logic [N_PM-1:0]      pm_pin_oe,
    output logic [N_PM-1:0]      pm_in_en
);
    localparam int N_STRAP = FS_W + 2;
    localparam int MODE_B  = FS_W;
    localparam int VSEL_B  = FS_W + 1;

    logic               capture;
    logic               drive;
    logic [N_STRAP-1:0] strap_q;

    strap_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .drive   (drive)
    );

    strap_latch #(.W(N_STRAP)) u_latch (
        .clk    (clk),
        .cap_en (capture),
        .d      (pad_in),
        .q      (strap_q)
    );

    assign strap_fsel = strap_q[FS_W-1:0];
    assign strap_mode = strap_q[MODE_B];
    assign strap_vsel = strap_q[VSEL_B];

    fsel_mux #(.W(FS_W)) u_mux (
        .use_reg    (reg_fsel_src),
        .strap_code (strap_fsel),
        .reg_code   (reg_fsel),
        .eff_code   (eff_fsel)
    );

    for (genvar p = 0; p < N_STRAP; p++) begin : g_pad
        assign pad_oe[p] = drive;
    end

    for (genvar s = 0; s < N_PM; s++) begin : g_pm
        assign pm_pin_oe[s] = drive &  strap_mode;
        assign pm_in_en[s]  = drive & ~strap_mode;
    end
endmodule

// File: rtl/strap_pin_ctrl_chk.sv
module strap_pin_ctrl_chk #(
    parameter int FS_W = 3,
    parameter int N_PM = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [FS_W+1:0] pad_oe,
    input logic [FS_W-1:0] strap_fsel,
    input logic            strap_mode,
    input logic            strap_vsel,
    input logic [FS_W-1:0] reg_fsel,
    input logic            reg_fsel_src,
    input logic [FS_W-1:0] eff_fsel,
    input logic [N_PM-1:0] pm_pin_oe,
    input logic [N_PM-1:0] pm_in_en
);
    logic       seen  = 1'b0;
    logic       rst_q = 1'b0;
    logic [1:0] rel_cnt = 2'd0;

    always @(posedge clk) begin
        seen  <= 1'b1;
        rst_q <= rst_n;
        if (!rst_n) rel_cnt <= 2'd0;
        else if (rel_cnt != 2'd2) rel_cnt <= rel_cnt + 2'd1;
    end

    // R1
    always @(negedge clk) begin
        if (seen && !rst_q) begin
            rst_quiet_chk: assert (pad_oe == '0 && pm_pin_oe == '0 && pm_in_en == '0);
        end
    end

    // R3
    guard_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_cnt != 2'd2) |-> (pad_oe == '0));

    // R3
    drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_cnt == 2'd2) |-> (&pad_oe));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable({strap_vsel, strap_mode, strap_fsel}));

    // R5
    fsel_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_fsel_src |-> (eff_fsel == reg_fsel));

    // R5
    fsel_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_fsel_src |-> (eff_fsel == strap_fsel));

    // R6
    pin_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[0] |-> (pm_pin_oe == {N_PM{strap_mode}} && pm_in_en == {N_PM{!strap_mode}}));

    // R7
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&pad_oe) |=> (&pad_oe));
endmodule

bind strap_pin_ctrl strap_pin_ctrl_chk #(.FS_W(FS_W), .N_PM(N_PM)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pad_oe       (pad_oe),
    .strap_fsel   (strap_fsel),
    .strap_mode   (strap_mode),
    .strap_vsel   (strap_vsel),
    .reg_fsel     (reg_fsel),
    .reg_fsel_src (reg_fsel_src),
    .eff_fsel     (eff_fsel),
    .pm_pin_oe    (pm_pin_oe),
    .pm_in_en     (pm_in_en)
);

// File: tb/strap_pin_ctrl_bench.sv
module strap_pin_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pad_in = 5'd0;
    logic [2:0] reg_fsel = 3'd0;
    logic       reg_fsel_src = 1'b0;
    logic [4:0] pad_oe;
    logic [2:0] strap_fsel;
    logic       strap_mode;
    logic       strap_vsel;
    logic [2:0] eff_fsel;
    logic [3:0] pm_pin_oe;
    logic [3:0] pm_in_en;

    int total = 0;
    int bad   = 0;

    strap_pin_ctrl u_strap_pin_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pad_in       (pad_in),
        .reg_fsel     (reg_fsel),
        .reg_fsel_src (reg_fsel_src),
        .pad_oe       (pad_oe),
        .strap_fsel   (strap_fsel),
        .strap_mode   (strap_mode),
        .strap_vsel   (strap_vsel),
        .eff_fsel     (eff_fsel),
        .pm_pin_oe    (pm_pin_oe),
        .pm_in_en     (pm_in_en)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reset with junk pads, final strap value on last edge, junk right after release
    task automatic boot(input logic [4:0] val);
        @(negedge clk);
        rst_n  = 1'b0;
        pad_in = ~val;
        repeat (3) @(negedge clk);
        check("R1", {27'd0, pad_oe}, 32'd0);
        check("R1", {24'd0, pm_pin_oe, pm_in_en}, 32'd0);
        pad_in = val;
        @(negedge clk);
        rst_n  = 1'b1;
        pad_in = ~val;
        @(negedge clk);
        check("R3", {27'd0, pad_oe}, 32'd0);
        check("R2", {27'd0, strap_vsel, strap_mode, strap_fsel}, {27'd0, val});
        @(negedge clk);
        check("R3", {27'd0, pad_oe}, 32'h1f);
    endtask

    task automatic t_desktop;
        boot(5'b0_1_101);
        check("R6", {28'd0, pm_pin_oe}, 32'hf);
        check("R6", {28'd0, pm_in_en}, 32'h0);
        check("R2", {31'd0, strap_vsel}, 32'd0);
    endtask

    task automatic t_mobile_hold;
        boot(5'b1_0_010);
        check("R6", {28'd0, pm_pin_oe}, 32'h0);
        check("R6", {28'd0, pm_in_en}, 32'hf);
        check("R2", {31'd0, strap_vsel}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            pad_in = 5'(i * 7 + 3);
            @(negedge clk);
            check("R4", {27'd0, strap_vsel, strap_mode, strap_fsel}, 32'b1_0_010);
            check("R7", {27'd0, pad_oe}, 32'h1f);
        end
    endtask

    task automatic t_fsel_src;
        boot(5'b0_0_110);
        reg_fsel_src = 1'b0;
        reg_fsel     = 3'b001;
        @(negedge clk);
        check("R5", {29'd0, eff_fsel}, 32'd6);
        reg_fsel_src = 1'b1;
        @(negedge clk);
        check("R5", {29'd0, eff_fsel}, 32'd1);
        reg_fsel = 3'b111;
        @(negedge clk);
        check("R5", {29'd0, eff_fsel}, 32'd7);
        reg_fsel_src = 1'b0;
        @(negedge clk);
        check("R5", {29'd0, eff_fsel}, 32'd6);
    endtask

    task automatic t_rereset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", {27'd0, pad_oe}, 32'd0);
        boot(5'b1_1_000);
        check("R8", {27'd0, strap_vsel, strap_mode, strap_fsel}, 32'b1_1_000);
        check("R8", {28'd0, pm_pin_oe}, 32'hf);
    endtask

    initial begin
        t_desktop();
        t_mobile_hold();
        t_fsel_src();
        t_rereset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule